// File: doc/BRIEF.md
# Gray-Scale Pulse-Width Channel Driver Core

This block is the digital heart of a 64-channel print-head driver. A line of 4-bit gray codes is streamed in, one channel per shift enable, through a chain of 64 four-bit stages. A latch enable copies the whole chain into a holding register, so the next line can be streamed while the current one prints. A shared step counter is restarted by a restart pulse and advanced by a strobe-step enable. On every step, each channel compares the count with its held code and records the result in a per-channel enable register. The registered enable is gated by one of several group strobes to form the channel output. A code of c therefore keeps its channel on for exactly c step periods, which gives 16 on-time levels.

The last stage of the chain is driven out as a cascade output, so several blocks can be chained on one data stream. All activity is synchronous to one clock. The shift, latch, step and restart inputs are single-cycle enables. An asynchronous active-low reset is released through a two-flop synchronizer, so internal state leaves reset on the second clock edge after `rst_n` rises.

Top module: `gsdrv_core`

## Requirements
- R1: While reset is active, and after it, until new data is latched, every `chan_on` bit and `cascade_out` are 0.
- R2: On each cycle with `shift_en` high, `din` enters stage 0 and every stage moves one place towards stage CH-1. `cascade_out` shows stage CH-1. With `shift_en` low, no stage and no `cascade_out` value changes.
- R3: After CH shifts, the first code shifted sits in channel CH-1 and the last one in channel 0. Channel k's code occupies bits [k*CW +: CW] of the held line.
- R4: A cycle with `latch_en` high copies every stage into the held line. If a shift happens in the same cycle, the held line gets the stage contents from before that shift. Without `latch_en`, the held line does not change.
- R5: `restart` sets the step count to 0. Each `step_en` cycle without `restart` adds 1 to the count. When both are high, `restart` wins.
- R6: The count saturates at 2**CW-1 and does not wrap until the next `restart`.
- R7: On each `step_en` cycle, a channel's enable register takes the value (count < held code). After a restart, code c is on for exactly steps 1..c, so code 0 never turns on and code 15 is on for 15 steps.
- R8: Channel enables change only on a `step_en` or `restart` cycle. A new latched line does not alter the outputs until the next step.
- R9: `restart` clears every channel enable on the next edge.
- R10: Channel k belongs to strobe group k/(CH/GRP). `chan_on[k]` equals its enable ANDed with `strobe` of that group, with no register in between, so a low strobe forces its group off at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Shift one code from `din` into the chain |
| din | input | CW | Gray code entering stage 0 |
| latch_en | input | 1 | Copy the chain into the held line |
| step_en | input | 1 | Strobe step: advance count and update channel enables |
| restart | input | 1 | Restart the gray cycle: count to 0, enables cleared |
| strobe | input | GRP | Per-group output gate |
| chan_on | output | CH | Gated per-channel output enables |
| cascade_out | output | CW | Last chain stage, for cascading |

## Verification
The bench sweeps several line patterns and strobe masks, counting how many steps each channel stays on. A wrong comparison (≤ instead of <) or a wrapping counter would show up as a miscount or a second pulse. The chain order is checked through channel-specific codes, so reversed stage indexing would move codes to the wrong channels. A latch issued together with a shift must capture the old contents; a design that captured the new contents would print the freshly shifted code. The bench also covers two more cases. A restart arriving with a step must win, or the first pulse would be one step short. A line latched mid-cycle must not disturb the outputs, or a non-registered compare would glitch.

// File: rtl/gsdrv_pkg.sv
package gsdrv_pkg;
  localparam int unsigned GS_CH_DEF  = 64;
  localparam int unsigned GS_CW_DEF  = 4;
  localparam int unsigned GS_GRP_DEF = 4;
endpackage

// File: rtl/gsdrv_rst_sync.sv
module gsdrv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/gsdrv_line_store.sv
module gsdrv_line_store #(
  parameter int unsigned CH = gsdrv_pkg::GS_CH_DEF,
  parameter int unsigned CW = gsdrv_pkg::GS_CW_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [CW-1:0]    din,
  input  logic             latch_en,
  output logic [CH*CW-1:0] held_codes,
  output logic [CW-1:0]    cascade_out
);
  localparam int unsigned LINE_W = CH * CW;
  localparam int unsigned KEEP_W = (CH - 1) * CW;

  logic [LINE_W-1:0] stage_q, stage_d;
  logic [LINE_W-1:0] held_q,  held_d;

  // Chain: stage 0 in the low bits, each shift moves codes upward.
  always_comb begin
    stage_d = stage_q;
    if (shift_en) stage_d = {stage_q[KEEP_W-1:0], din};
  end

  // Held line samples the chain as it stood before this edge.
  always_comb begin
    held_d = held_q;
    if (latch_en) held_d = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      held_q  <= '0;
    end else begin
      stage_q <= stage_d;
      held_q  <= held_d;
    end
  end

  assign held_codes  = held_q;
  assign cascade_out = stage_q[KEEP_W +: CW];
endmodule

// File: rtl/gsdrv_step_ctr.sv
module gsdrv_step_ctr #(
  parameter int unsigned CW = gsdrv_pkg::GS_CW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          restart,
  output logic [CW-1:0] step_cnt
);
  localparam logic [CW-1:0] CNT_TOP = '1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)                         cnt_d = '0;
    else if (step_en && cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign step_cnt = cnt_q;
endmodule

// File: rtl/gsdrv_onoff.sv
module gsdrv_onoff #(
  parameter int unsigned CH  = gsdrv_pkg::GS_CH_DEF,
  parameter int unsigned CW  = gsdrv_pkg::GS_CW_DEF,
  parameter int unsigned GRP = gsdrv_pkg::GS_GRP_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             restart,
  input  logic [CW-1:0]    step_cnt,
  input  logic [CH*CW-1:0] held_codes,
  input  logic [GRP-1:0]   strobe,
  output logic [CH-1:0]    hold_on,
  output logic [CH-1:0]    chan_on
);
  localparam int unsigned GSIZE = CH / GRP;

  logic [CH-1:0] cmp_hit;
  logic [CH-1:0] grp_gate;
  logic [CH-1:0] en_q, en_d;

  for (genvar c = 0; c < CH; c++) begin : g_chan
    localparam int unsigned GIDX = c / GSIZE;
    assign cmp_hit[c]  = (step_cnt < held_codes[c*CW +: CW]);
    assign grp_gate[c] = strobe[GIDX];
  end

  always_comb begin
    en_d = en_q;
    if (restart)      en_d = '0;
    else if (step_en) en_d = cmp_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign hold_on = en_q;
  assign chan_on = en_q & grp_gate;
endmodule

// File: rtl/gsdrv_core.sv
module gsdrv_core #(
  parameter int unsigned CH  = gsdrv_pkg::GS_CH_DEF,
  parameter int unsigned CW  = gsdrv_pkg::GS_CW_DEF,
  parameter int unsigned GRP = gsdrv_pkg::GS_GRP_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic [CW-1:0]  din,
  input  logic           latch_en,
  input  logic           step_en,
  input  logic           restart,
  input  logic [GRP-1:0] strobe,
  output logic [CH-1:0]  chan_on,
  output logic [CW-1:0]  cascade_out
);
  logic             rst_sync_n;
  logic [CH*CW-1:0] held_codes;
  logic [CW-1:0]    step_cnt;
  logic [CH-1:0]    hold_on;

  gsdrv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gsdrv_line_store #(.CH(CH), .CW(CW)) u_line (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .shift_en    (shift_en),
    .din         (din),
    .latch_en    (latch_en),
    .held_codes  (held_codes),
    .cascade_out (cascade_out)
  );

  gsdrv_step_ctr #(.CW(CW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .step_en  (step_en),
    .restart  (restart),
    .step_cnt (step_cnt)
  );

  gsdrv_onoff #(.CH(CH), .CW(CW), .GRP(GRP)) u_onoff (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .step_en    (step_en),
    .restart    (restart),
    .step_cnt   (step_cnt),
    .held_codes (held_codes),
    .strobe     (strobe),
    .hold_on    (hold_on),
    .chan_on    (chan_on)
  );
endmodule

// File: rtl/gsdrv_core_chk.sv
module gsdrv_core_chk #(
  parameter int unsigned CH  = gsdrv_pkg::GS_CH_DEF,
  parameter int unsigned CW  = gsdrv_pkg::GS_CW_DEF,
  parameter int unsigned GRP = gsdrv_pkg::GS_GRP_DEF
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             shift_en,
  input logic             latch_en,
  input logic             step_en,
  input logic             restart,
  input logic [GRP-1:0]   strobe,
  input logic [CH-1:0]    chan_on,
  input logic [CW-1:0]    cascade_out,
  input logic [CW-1:0]    step_cnt,
  input logic [CH-1:0]    hold_on,
  input logic [CH*CW-1:0] held_codes
);
  localparam int unsigned   GSIZE   = CH / GRP;
  localparam logic [CW-1:0] CNT_TOP = '1;

  assert_cascade_still_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !shift_en |=> $stable(cascade_out));

  assert_line_kept_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !latch_en |=> $stable(held_codes));

  assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    restart |=> step_cnt == '0);

  assert_count_up_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_en && !restart && step_cnt != CNT_TOP) |=> step_cnt == $past(step_cnt) + 1'b1);

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_cnt == CNT_TOP && !restart) |=> step_cnt == CNT_TOP);

  assert_enables_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!step_en && !restart) |=> $stable(hold_on));

  assert_restart_dark_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    restart |=> hold_on == '0);

  for (genvar g = 0; g < GRP; g++) begin : g_grp
    assert_group_gated_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !strobe[g] |-> chan_on[g*GSIZE +: GSIZE] == '0);
  end
endmodule

bind gsdrv_core gsdrv_core_chk #(.CH(CH), .CW(CW), .GRP(GRP)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .shift_en    (shift_en),
  .latch_en    (latch_en),
  .step_en     (step_en),
  .restart     (restart),
  .strobe      (strobe),
  .chan_on     (chan_on),
  .cascade_out (cascade_out),
  .step_cnt    (step_cnt),
  .hold_on     (hold_on),
  .held_codes  (held_codes)
);

// File: tb/gsdrv_core_tb.sv
module gsdrv_core_tb;
  localparam int CH    = 64;
  localparam int CW    = 4;
  localparam int GRP   = 4;
  localparam int GSIZE = CH / GRP;

  typedef struct packed {
    logic [3:0] seed;
    logic [3:0] stride;
    logic [3:0] stb;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'd0,  4'd1, 4'hF},
    '{4'd15, 4'd0, 4'hF},
    '{4'd0,  4'd0, 4'hF},
    '{4'd3,  4'd5, 4'hA},
    '{4'd7,  4'd3, 4'h5},
    '{4'd9,  4'd7, 4'h6}
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic           shift_en, latch_en, step_en, restart;
  logic [CW-1:0]  din;
  logic [GRP-1:0] strobe;
  logic [CH-1:0]  chan_on;
  logic [CW-1:0]  cascade_out;

  int checks = 0;
  int errors = 0;
  logic [3:0] line_q [CH];
  int on_cnt [CH];

  always #4 clk = ~clk;

  gsdrv_core #(.CH(CH), .CW(CW), .GRP(GRP)) u_dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(din),
    .latch_en(latch_en), .step_en(step_en), .restart(restart),
    .strobe(strobe), .chan_on(chan_on), .cascade_out(cascade_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_code(input int ch);
    return int'(line_q[CH-1-ch]);
  endfunction

  task automatic shift_one(input logic [3:0] c);
    din = c; shift_en = 1'b1; tick(); shift_en = 1'b0;
  endtask

  task automatic fill_line(input logic [3:0] seed, input logic [3:0] stride);
    for (int j = 0; j < CH; j++) begin
      line_q[j] = 4'(int'(seed) + int'(stride) * j);
      shift_one(line_q[j]);
    end
  endtask

  task automatic latch_now();
    latch_en = 1'b1; tick(); latch_en = 1'b0;
  endtask

  task automatic restart_now();
    restart = 1'b1; tick(); restart = 1'b0;
  endtask

  task automatic step_now();
    step_en = 1'b1; tick(); step_en = 1'b0;
  endtask

  task automatic run_gray();
    restart_now();
    for (int ch = 0; ch < CH; ch++) on_cnt[ch] = 0;
    for (int s = 0; s < 18; s++) begin
      step_now();
      for (int ch = 0; ch < CH; ch++) if (chan_on[ch]) on_cnt[ch]++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; shift_en = 1'b0; latch_en = 1'b0; step_en = 1'b0;
    restart = 1'b0; din = '0; strobe = '1;
    repeat (3) tick();
    check(chan_on == '0, "R1 chan_on in reset", int'(chan_on != '0), 0);
    check(cascade_out == '0, "R1 cascade in reset", int'(cascade_out), 0);
    rst_n = 1'b1;
    repeat (3) tick();
    restart_now(); step_now();
    check(chan_on == '0, "R1 no output before latch", int'(chan_on != '0), 0);

    // Table-driven sweep: R7 on-time, R10 group gating, R2/R3 cascade.
    for (int v = 0; v < 6; v++) begin
      fill_line(VECS[v].seed, VECS[v].stride);
      check(cascade_out == line_q[0], "R2 R3 cascade shows first code",
            int'(cascade_out), int'(line_q[0]));
      latch_now();
      strobe = VECS[v].stb;
      run_gray();
      for (int ch = 0; ch < CH; ch++) begin
        int e;
        e = VECS[v].stb[ch / GSIZE] ? exp_code(ch) : 0;
        check(on_cnt[ch] == e, "R7 R10 on-step count", on_cnt[ch], e);
      end
    end
    strobe = '1;

    // R2: no shift, no movement; one shift moves the chain.
    fill_line(4'd4, 4'd3);
    din = 4'hE; repeat (3) tick();
    check(cascade_out == line_q[0], "R2 hold without shift", int'(cascade_out), int'(line_q[0]));
    shift_one(4'h9);
    check(cascade_out == line_q[1], "R2 one shift", int'(cascade_out), int'(line_q[1]));

    // R3: channel mapping, seed 0 stride 1 -> ch62 holds code 1, ch63 code 0.
    fill_line(4'd0, 4'd1);
    latch_now(); restart_now(); step_now();
    check(chan_on[62] == 1'b1, "R3 ch62 code1 on step1", int'(chan_on[62]), 1);
    check(chan_on[63] == 1'b0, "R3 ch63 code0 off", int'(chan_on[63]), 0);
    step_now();
    check(chan_on[62] == 1'b0, "R3 ch62 off step2", int'(chan_on[62]), 0);
    check(chan_on[61] == 1'b1, "R3 ch61 code2 on step2", int'(chan_on[61]), 1);

    // R4: latch with a shift in the same cycle keeps the pre-shift line.
    fill_line(4'd2, 4'd0);
    din = 4'hC; shift_en = 1'b1; latch_en = 1'b1; tick();
    shift_en = 1'b0; latch_en = 1'b0;
    run_gray();
    check(on_cnt[0] == 2, "R4 latch takes old stage", on_cnt[0], 2);

    // R8: new latched line does not touch outputs until next step.
    fill_line(4'd8, 4'd0);
    latch_now(); restart_now();
    repeat (3) step_now();
    check(chan_on == '1, "R8 all on at count 2", int'(chan_on != '1), 0);
    fill_line(4'd0, 4'd0);
    latch_now(); repeat (2) tick();
    check(chan_on == '1, "R8 unchanged after new latch", int'(chan_on != '1), 0);
    step_now();
    check(chan_on == '0, "R8 next step applies new line", int'(chan_on != '0), 0);

    // R10: strobe gating is immediate.
    fill_line(4'd8, 4'd0);
    latch_now(); restart_now(); step_now();
    strobe = 4'b1011; #1;
    check(chan_on[47:32] == '0, "R10 group2 forced off", int'(chan_on[47:32]), 0);
    check(chan_on[31:0] == '1, "R10 others stay on", int'(chan_on[31:0] != '1), 0);
    strobe = '1; #1;
    check(chan_on == '1, "R10 restored", int'(chan_on != '1), 0);
    @(negedge clk);

    // R6: saturation, no second pulse; R5: restart starts again.
    fill_line(4'd15, 4'd0);
    latch_now(); restart_now();
    repeat (15) step_now();
    check(chan_on[0] == 1'b1, "R6 code15 on at step15", int'(chan_on[0]), 1);
    step_now();
    check(chan_on[0] == 1'b0, "R6 off at step16", int'(chan_on[0]), 0);
    begin
      int seen;
      seen = 0;
      for (int s = 0; s < 30; s++) begin
        step_now();
        if (chan_on != '0) seen++;
      end
      check(seen == 0, "R6 no wrap", seen, 0);
    end
    restart_now(); step_now();
    check(chan_on[0] == 1'b1, "R5 restart begins new cycle", int'(chan_on[0]), 1);

    // R9: restart clears enables; R5: restart beats step.
    restart_now();
    check(chan_on == '0, "R9 restart clears", int'(chan_on != '0), 0);
    fill_line(4'd1, 4'd0);
    latch_now(); restart_now();
    repeat (5) step_now();
    restart = 1'b1; step_en = 1'b1; tick(); restart = 1'b0; step_en = 1'b0;
    check(chan_on == '0, "R9 restart with step clears", int'(chan_on != '0), 0);
    step_now();
    check(chan_on == '1, "R5 restart won, count was 0", int'(chan_on != '1), 0);

    // R1: asynchronous reset clears live outputs.
    rst_n = 1'b0; #1;
    check(chan_on == '0, "R1 async reset outputs", int'(chan_on != '0), 0);
    check(cascade_out == '0, "R1 async reset cascade", int'(cascade_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule